// File: doc/BRIEF.md
# Dual-Slot Smart Card Power Sequencer

This block controls two smart card slots that share one host interface. Three host inputs decide what happens. An enable input turns the interface on or off. A slot select picks slot A or slot B. A class select picks the supply class of that slot. From these inputs the block drives one regulator enable per slot and a class bit per slot. It also drives three force-low controls per slot, one each for the card reset, card clock and card data lines, and a data routing select that tells the level-shifting fabric which slot the host data line talks to.

On activation the block powers the chosen slot's regulator and waits for that slot's supply-good flag. After a programmable settle delay it releases reset and data together. The card clock follows on the second rising edge of the host clock. On deactivation reset is dropped at once. The clock stops after two host clock rising edges if those edges arrive, and otherwise at the end of a fixed off delay. Data is forced low at the end of the off delay, and the regulator is switched off one cycle after that.

A host-side undervoltage flag moves the block straight to shutdown. A change of the selects while a slot is live causes a full deactivation of the old slot, followed by a fresh activation of the new one. Delays are counted in ticks of a free-running timebase, so the analog timing is set by parameters rather than by logic changes.

Top module: `dual_slot_pwr_seq`

## Requirements
- R1: When `en_i` is low, both regulator enables are 0 once any deactivation in progress has finished. When `en_i` is high, `slot_sel_i` = 0 picks slot A (index 0) and `slot_sel_i` = 1 picks slot B (index 1).
- R2: `class_sel_i` = 0 selects the 1.8 V class and `class_sel_i` = 1 selects the 3.0 V class. `vclass_o[s]` is 1 only for a powered slot of the 3.0 V class, and it is 0 for an unpowered slot. The class is latched when activation starts.
- R3: The two regulator enables are never both 1. An unselected slot has its regulator enable at 0 and all three force-low bits at 1.
- R4: When `en_i` is sampled high in idle, the selected regulator enable is 1 on the next cycle. While the supply ramps, `rst_frc_o`, `clk_frc_o` and `dat_frc_o` stay 1 for that slot.
- R5: The timebase ticks every TICK_DIV clocks, counted from reset. Reset and data are released when the REL_TICKS-th tick after the supply-good flag of the slot was sampled high has been taken.
- R6: The card clock force-low bit is cleared on the cycle after the second host-clock rising edge seen after the release of reset and data. It stays set before that edge.
- R7: When `en_i` is sampled low while a slot is live, `rst_frc_o` for that slot is 1 on the next cycle.
- R8: During deactivation, a clock that was running stops after the second host-clock rising edge counted from the start of deactivation. If no such edge arrives, it stops when the off delay ends.
- R9: Data is forced low when the OFF_TICKS-th tick of deactivation is taken. The regulator enable drops one cycle later.
- R10: When `uv_i` is sampled high, all regulator enables are 0 and all force-low bits are 1 on the next cycle. They stay that way while `uv_i` is high.
- R11: `route_o` equals the index of the slot that was selected at the last activation. A powered regulator is always the routed one.
- R12: A change of `slot_sel_i` or `class_sel_i` while a slot is live leads through a full deactivation and idle to a new ramp of the newly selected slot.
- R13: `phase_o` encodes idle = 0, ramp = 1, settle wait = 2, clock arm = 3, active = 4 and deactivating = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Interface enable from the host |
| slot_sel_i | input | 1 | Slot select (0 = A, 1 = B) |
| class_sel_i | input | 1 | Supply class select (0 = 1.8 V, 1 = 3.0 V) |
| hclk_i | input | 1 | Host card clock, sampled by the system clock |
| pgood_i | input | 2 | Supply-good flag per slot |
| uv_i | input | 1 | Host-side supply undervoltage flag |
| reg_en_o | output | 2 | Regulator enable per slot |
| vclass_o | output | 2 | Class bit per slot (1 = 3.0 V) |
| rst_frc_o | output | 2 | Card reset force-low per slot |
| clk_frc_o | output | 2 | Card clock force-low per slot |
| dat_frc_o | output | 2 | Card data force-low per slot |
| route_o | output | 1 | Host data routing select |
| phase_o | output | 3 | Sequencer phase code |

## Verification
The bench aims at the orderings that are easiest to get wrong. Clock release must wait for the second host edge; a design that released on the first edge would start the card clock while reset had barely moved. In deactivation, the clock must stop by host edges when they arrive and by the off timer when the host clock is stalled; a design that relied on edges alone would leave the clock running into supply removal. Further cases cover a select change in the middle of a session, which must not hop supplies without a full off sequence, and undervoltage arriving during an active session. Regulator overlap and a supply turned off while data is still released are also checked against a cycle-accurate behavioural model on every clock.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_RAMP   = 3'd1,
      PH_WAIT   = 3'd2,
      PH_ARM    = 3'd3,
      PH_ACTIVE = 3'd4,
      PH_DEACT  = 3'd5
   } phase_e;

endpackage

// File: rtl/slotseq_timebase.sv
module slotseq_timebase #(
   parameter int unsigned DIV = 200
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("slotseq_timebase: DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/slotseq_core.sv
module slotseq_core
   import slotseq_pkg::*;
#(
   parameter int unsigned REL_TICKS = 800,
   parameter int unsigned OFF_TICKS = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       en_i,
   input  logic       slot_sel_i,
   input  logic       class_sel_i,
   input  logic       hclk_i,
   input  logic [1:0] pgood_i,
   input  logic       uv_i,
   output phase_e     phase_o,
   output logic       slot_o,
   output logic       class_o,
   output logic       pwr_on_o,
   output logic       rst_on_o,
   output logic       clk_on_o,
   output logic       dat_on_o
);
   localparam int unsigned DMAX = (REL_TICKS > OFF_TICKS) ? REL_TICKS : OFF_TICKS;
   localparam int unsigned DW   = $clog2(DMAX + 1);
   localparam logic [DW-1:0] REL_LAST = DW'(REL_TICKS - 1);
   localparam logic [DW-1:0] OFF_LAST = DW'(OFF_TICKS - 1);

   generate
      if (REL_TICKS < 1 || OFF_TICKS < 1) begin : g_bad_dly
         $error("slotseq_core: tick counts must be at least 1");
      end
   endgenerate

   phase_e        ph_q;
   logic          slot_q, cls_q, clk_run_q, dat_run_q, done_q, hclk_q;
   logic [DW-1:0] dly_q;
   logic [1:0]    hcnt_q;
   logic          hedge, chg;

   assign hedge = hclk_i & ~hclk_q;
   assign chg   = (slot_sel_i != slot_q) || (class_sel_i != cls_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q      <= PH_IDLE;
         slot_q    <= 1'b0;
         cls_q     <= 1'b0;
         clk_run_q <= 1'b0;
         dat_run_q <= 1'b0;
         done_q    <= 1'b0;
         hclk_q    <= 1'b0;
         dly_q     <= '0;
         hcnt_q    <= '0;
      end else begin
         hclk_q <= hclk_i;
         if (uv_i) begin
            ph_q      <= PH_IDLE;
            clk_run_q <= 1'b0;
            dat_run_q <= 1'b0;
            done_q    <= 1'b0;
         end else begin
            case (ph_q)
               PH_IDLE: begin
                  if (en_i) begin
                     ph_q   <= PH_RAMP;
                     slot_q <= slot_sel_i;
                     cls_q  <= class_sel_i;
                  end
               end
               PH_DEACT: begin
                  if (done_q) begin
                     ph_q   <= PH_IDLE;
                     done_q <= 1'b0;
                  end else begin
                     if (hedge && hcnt_q != 2'd2) hcnt_q <= hcnt_q + 2'd1;
                     if (hedge && hcnt_q == 2'd1) clk_run_q <= 1'b0;
                     if (tick_i) begin
                        if (dly_q == OFF_LAST) begin
                           dat_run_q <= 1'b0;
                           clk_run_q <= 1'b0;
                           done_q    <= 1'b1;
                        end else begin
                           dly_q <= dly_q + DW'(1);
                        end
                     end
                  end
               end
               default: begin
                  if (!en_i || chg) begin
                     ph_q      <= PH_DEACT;
                     dly_q     <= '0;
                     hcnt_q    <= '0;
                     done_q    <= 1'b0;
                     clk_run_q <= (ph_q == PH_ACTIVE);
                     dat_run_q <= (ph_q == PH_ARM) || (ph_q == PH_ACTIVE);
                  end else if (ph_q == PH_RAMP) begin
                     if (pgood_i[slot_q]) begin
                        ph_q  <= PH_WAIT;
                        dly_q <= '0;
                     end
                  end else if (ph_q == PH_WAIT) begin
                     if (tick_i) begin
                        if (dly_q == REL_LAST) begin
                           ph_q   <= PH_ARM;
                           hcnt_q <= '0;
                        end else begin
                           dly_q <= dly_q + DW'(1);
                        end
                     end
                  end else if (ph_q == PH_ARM) begin
                     if (hedge) begin
                        if (hcnt_q == 2'd1) ph_q <= PH_ACTIVE;
                        else                hcnt_q <= hcnt_q + 2'd1;
                     end
                  end
               end
            endcase
         end
      end
   end

   assign phase_o  = ph_q;
   assign slot_o   = slot_q;
   assign class_o  = cls_q;
   assign pwr_on_o = (ph_q != PH_IDLE);
   assign rst_on_o = (ph_q == PH_ARM) || (ph_q == PH_ACTIVE);
   assign clk_on_o = (ph_q == PH_ACTIVE) || ((ph_q == PH_DEACT) && clk_run_q);
   assign dat_on_o = (ph_q == PH_ARM) || (ph_q == PH_ACTIVE) ||
                     ((ph_q == PH_DEACT) && dat_run_q);

   p_rst_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && ph_q != PH_IDLE) |=> !rst_on_o)
      else $error("reset not forced at deactivation");

   p_uv_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_i |=> (ph_q == PH_IDLE))
      else $error("undervoltage did not shut down");

   p_clk_from_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_on_o) |-> ($past(ph_q) == PH_ARM))
      else $error("clock released outside arm phase");

   p_dat_before_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(pwr_on_o) && !$past(uv_i)) |-> ($past(dat_on_o) == 1'b0))
      else $error("supply removed while data released");

   p_class_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_on_o && $past(pwr_on_o)) |-> $stable(cls_q))
      else $error("class changed while powered");

endmodule

// File: rtl/slotseq_slot_drv.sv
module slotseq_slot_drv #(
   parameter bit IDX = 1'b0
) (
   input  logic slot_i,
   input  logic cls_i,
   input  logic pwr_i,
   input  logic rst_on_i,
   input  logic clk_on_i,
   input  logic dat_on_i,
   output logic reg_en_o,
   output logic vcls_o,
   output logic rst_frc_o,
   output logic clk_frc_o,
   output logic dat_frc_o
);
   logic mine;

   assign mine      = (slot_i == IDX);
   assign reg_en_o  = mine & pwr_i;
   assign vcls_o    = mine & pwr_i & cls_i;
   assign rst_frc_o = ~(mine & rst_on_i);
   assign clk_frc_o = ~(mine & clk_on_i);
   assign dat_frc_o = ~(mine & dat_on_i);

endmodule

// File: rtl/dual_slot_pwr_seq.sv
module dual_slot_pwr_seq
   import slotseq_pkg::*;
#(
   parameter int unsigned TICK_DIV  = 200,
   parameter int unsigned REL_TICKS = 800,
   parameter int unsigned OFF_TICKS = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       en_i,
   input  logic       slot_sel_i,
   input  logic       class_sel_i,
   input  logic       hclk_i,
   input  logic [1:0] pgood_i,
   input  logic       uv_i,
   output logic [1:0] reg_en_o,
   output logic [1:0] vclass_o,
   output logic [1:0] rst_frc_o,
   output logic [1:0] clk_frc_o,
   output logic [1:0] dat_frc_o,
   output logic       route_o,
   output logic [2:0] phase_o
);
   localparam int unsigned NSLOT = 2;

   logic   tick;
   phase_e phase;
   logic   slot, cls, pwr_on, rst_on, clk_on, dat_on;

   slotseq_timebase #(.DIV(TICK_DIV)) u_tb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   slotseq_core #(.REL_TICKS(REL_TICKS), .OFF_TICKS(OFF_TICKS)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .en_i        (en_i),
      .slot_sel_i  (slot_sel_i),
      .class_sel_i (class_sel_i),
      .hclk_i      (hclk_i),
      .pgood_i     (pgood_i),
      .uv_i        (uv_i),
      .phase_o     (phase),
      .slot_o      (slot),
      .class_o     (cls),
      .pwr_on_o    (pwr_on),
      .rst_on_o    (rst_on),
      .clk_on_o    (clk_on),
      .dat_on_o    (dat_on)
   );

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         slotseq_slot_drv #(.IDX(1'(s))) u_drv (
            .slot_i    (slot),
            .cls_i     (cls),
            .pwr_i     (pwr_on),
            .rst_on_i  (rst_on),
            .clk_on_i  (clk_on),
            .dat_on_i  (dat_on),
            .reg_en_o  (reg_en_o[s]),
            .vcls_o    (vclass_o[s]),
            .rst_frc_o (rst_frc_o[s]),
            .clk_frc_o (clk_frc_o[s]),
            .dat_frc_o (dat_frc_o[s])
         );
      end
   endgenerate

   assign route_o = slot;
   assign phase_o = phase;

   p_one_supply_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(reg_en_o[0] && reg_en_o[1]))
      else $error("both slot supplies enabled");

   p_route_powered_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|reg_en_o) |-> reg_en_o[route_o])
      else $error("powered slot is not the routed slot");

endmodule

// File: tb/dual_slot_pwr_seq_test.sv
`timescale 1ns/1ps
module dual_slot_pwr_seq_test;
   localparam int DIV = 4;
   localparam int REL = 5;
   localparam int OFF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, slot_sel = 1'b0, class_sel = 1'b0, hclk = 1'b0, uv = 1'b0;
   logic [1:0] pg = 2'b00;
   logic [1:0] reg_en, vclass, rst_frc, clk_frc, dat_frc;
   logic       route;
   logic [2:0] phase;
   logic       hclk_run = 1'b1;
   int         hdiv = 0;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dual_slot_pwr_seq #(.TICK_DIV(DIV), .REL_TICKS(REL), .OFF_TICKS(OFF)) uut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .slot_sel_i(slot_sel),
      .class_sel_i(class_sel), .hclk_i(hclk), .pgood_i(pg), .uv_i(uv),
      .reg_en_o(reg_en), .vclass_o(vclass), .rst_frc_o(rst_frc),
      .clk_frc_o(clk_frc), .dat_frc_o(dat_frc), .route_o(route), .phase_o(phase)
   );

   always @(negedge clk) begin
      if (hclk_run) begin
         hdiv = hdiv + 1;
         if (hdiv == 3) begin hclk <= ~hclk; hdiv = 0; end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_ph, m_slot, m_cls, m_tb, m_dly, m_h, m_clk, m_dat, m_done, m_hprev;
   bit tk, he;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_slot = 0; m_cls = 0; m_tb = 0; m_dly = 0;
         m_h = 0; m_clk = 0; m_dat = 0; m_done = 0; m_hprev = 0;
      end else begin
         tk = (m_tb == DIV - 1);
         m_tb = tk ? 0 : m_tb + 1;
         he = hclk && (m_hprev == 0);
         m_hprev = hclk;
         if (uv) begin
            m_ph = 0; m_clk = 0; m_dat = 0; m_done = 0;
         end else if (m_ph == 0) begin
            if (en) begin m_ph = 1; m_slot = slot_sel; m_cls = class_sel; end
         end else if (m_ph == 5) begin
            if (m_done != 0) begin m_ph = 0; m_done = 0; end
            else begin
               if (he) begin m_h++; if (m_h == 2) m_clk = 0; end
               if (tk) begin
                  m_dly++;
                  if (m_dly == OFF) begin m_dat = 0; m_clk = 0; m_done = 1; end
               end
            end
         end else if (!en || slot_sel != m_slot || class_sel != m_cls) begin
            m_clk = (m_ph == 4); m_dat = (m_ph >= 3);
            m_ph = 5; m_dly = 0; m_h = 0; m_done = 0;
         end else if (m_ph == 1) begin
            if (pg[m_slot]) begin m_ph = 2; m_dly = 0; end
         end else if (m_ph == 2) begin
            if (tk) begin m_dly++; if (m_dly == REL) begin m_ph = 3; m_h = 0; end end
         end else if (m_ph == 3) begin
            if (he) begin m_h++; if (m_h == 2) m_ph = 4; end
         end
      end
   end

   logic [1:0] e_reg, e_cls, e_rst, e_clk, e_dat;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int s = 0; s < 2; s++) begin
            e_reg[s] = (m_ph != 0) && (m_slot == s);
            e_cls[s] = e_reg[s] && (m_cls != 0);
            e_rst[s] = !((m_slot == s) && (m_ph == 3 || m_ph == 4));
            e_clk[s] = !((m_slot == s) && (m_ph == 4 || (m_ph == 5 && m_clk != 0)));
            e_dat[s] = !((m_slot == s) && (m_ph == 3 || m_ph == 4 || (m_ph == 5 && m_dat != 0)));
         end
         chk("R3 model regulator enables", reg_en, e_reg);
         chk("R2 model class bits", vclass, e_cls);
         chk("R5 model reset force", rst_frc, e_rst);
         chk("R8 model clock force", clk_frc, e_clk);
         chk("R9 model data force", dat_frc, e_dat);
         chk("R11 model route", route, m_slot);
         chk("R13 model phase", phase, m_ph);
      end
   end

   task automatic wait_ph(input int p);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (phase == p) break;
      end
   endtask

   initial begin
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset regulators off", reg_en, 0);
      chk("R13 reset phase idle", phase, 0);
      chk("R3 reset all forced", {rst_frc, clk_frc, dat_frc}, 6'h3f);

      // slot A, 3.0 V, slow supply
      slot_sel = 1'b0; class_sel = 1'b1; en = 1'b1;
      @(negedge clk);
      chk("R4 regulator on next cycle", reg_en, 2'b01);
      repeat (5) @(negedge clk);
      chk("R4 ramp phase", phase, 1);
      chk("R4 lines forced in ramp", {rst_frc[0], clk_frc[0], dat_frc[0]}, 3'b111);
      pg = 2'b11;
      n = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk); n++;
         if (rst_frc[0] == 1'b0) break;
      end
      chk("R5 release delay in window", (n >= 2 + (REL - 1) * DIV && n <= 1 + REL * DIV), 1);
      chk("R6 clock held at release", clk_frc[0], 1);
      wait_ph(4);
      chk("R6 clock released when active", clk_frc[0], 0);
      chk("R2 class 3.0 V on slot A", vclass, 2'b01);
      chk("R11 route to slot A", route, 0);

      // deactivate with host clock running
      en = 1'b0;
      @(negedge clk);
      chk("R7 reset forced after enable low", rst_frc[0], 1);
      wait_ph(0);
      chk("R1 all off after deactivation", reg_en, 0);

      // slot B, 1.8 V
      slot_sel = 1'b1; class_sel = 1'b0; en = 1'b1;
      wait_ph(4);
      chk("R1 slot B powered", reg_en, 2'b10);
      chk("R2 class 1.8 V on slot B", vclass, 2'b00);
      chk("R11 route to slot B", route, 1);

      // select change while active
      slot_sel = 1'b0;
      wait_ph(5);
      chk("R12 change triggers deactivation", phase, 5);
      chk("R12 old slot reset forced", rst_frc[1], 1);
      wait_ph(0);
      chk("R12 passes through idle", reg_en, 0);
      @(negedge clk);
      chk("R12 new slot ramps", reg_en, 2'b01);
      wait_ph(4);

      // deactivate with host clock stalled: timer stops the clock
      hclk_run = 1'b0;
      repeat (3) @(negedge clk);
      en = 1'b0;
      repeat (12) @(negedge clk);
      chk("R8 clock still running without host edges", clk_frc[0], 0);
      wait_ph(0);
      chk("R8 clock forced after off delay", clk_frc, 2'b11);

      // deactivation from clock arm with stalled host clock
      en = 1'b1;
      wait_ph(3);
      repeat (5) @(negedge clk);
      chk("R6 clock not released before edges", clk_frc, 2'b11);
      chk("R5 reset released in arm", rst_frc, 2'b10);
      en = 1'b0;
      wait_ph(0);
      hclk_run = 1'b1;

      // undervoltage during active session
      en = 1'b1;
      wait_ph(4);
      uv = 1'b1;
      @(negedge clk);
      chk("R10 supplies off on undervoltage", reg_en, 0);
      chk("R10 lines forced on undervoltage", {rst_frc, clk_frc, dat_frc}, 6'h3f);
      repeat (10) @(negedge clk);
      chk("R10 stays idle under undervoltage", phase, 0);
      uv = 1'b0;
      wait_ph(4);
      en = 1'b0;
      wait_ph(0);

      // selects toggle with enable low
      for (int i = 0; i < 8; i++) begin
         slot_sel = i[0]; class_sel = i[1];
         @(negedge clk);
         chk("R1 selects ignored while disabled", reg_en, 0);
      end

      repeat (4) @(negedge clk);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule